// File: doc/BRIEF.md
# Signed Fixed-Point Requantizer

This block narrows a signed two's-complement sample in two steps. First it removes a fixed number of low-order bits. The removal can truncate, or it can round with one of three rules for exact halves. Then it fits the rounded value into a narrower output word. This second step either drops the surplus high-order bits (wrap) or saturates to the extreme output codes (clip). A sample travels with a valid strobe. The result comes out two clock cycles later with a delayed valid and a flag that marks any change made by the second step.

One unit with the same parameters and mode encoding is meant to sit at every point of a signal path where word width must shrink. The quantization rule is then the same everywhere. The rounding and saturation modes are sampled together with each input word, so they may change from one sample to the next.

Top module: `rq_requant`

## Requirements
- R1: While `rst_n` is low, and on the first clock edges after release with no input accepted, `out_valid` and `out_ovf` are 0.
- R2: A sample presented with `in_valid`=1 at clock edge k appears on `out_data`/`out_ovf` with `out_valid`=1 after clock edge k+2; `out_valid` is 0 in all other cycles.
- R3: `round_mode`=0 (truncate) discards the DROP low bits, giving floor(x / 2^DROP). With DROP=4, -20 gives -2 and +20 gives +1.
- R4: `round_mode`=1 (half up) gives floor(x/2^DROP + 1/2), so an exact half moves toward plus infinity (-0.5 gives 0).
- R5: `round_mode`=2 (half away) rounds to the nearest integer and moves exact halves away from zero (-0.5 gives -1, +0.5 gives +1).
- R6: `round_mode`=3 (half even) rounds to the nearest integer and moves exact halves to the even neighbour (-1.5 gives -2, -0.5 gives 0, 0.5 gives 0, 1.5 gives 2, 2.5 gives 2).
- R7: Rounding keeps one extra high bit, so an upward carry out of the kept field reaches the second step. With the default sizes, +2047 in half-up rounds to +128, which clips to +31 or wraps to 0.
- R8: With DROP=0 the first step passes the value unchanged, whatever the rounding mode.
- R9: `sat_mode`=0 (wrap) keeps the low OUT_W bits of the rounded value as a two's-complement number.
- R10: `sat_mode`=1 (clip) replaces a rounded value outside the output range with -2^(OUT_W-1) or 2^(OUT_W-1)-1, according to its sign.
- R11: When OUT_W is wider than the rounded value, the output is the sign-extended value (-1 stays all ones) and `out_ovf` stays 0.
- R12: `out_ovf` is 1 in the output cycle exactly when the value on `out_data` differs from the rounded value, in both wrap and clip modes.
- R13: The modes are captured with each sample, so consecutive samples with different modes are each processed with their own modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| round_mode | input | 2 | 0 truncate, 1 half up, 2 half away, 3 half even |
| sat_mode | input | 1 | 0 wrap, 1 clip |
| out_valid | output | 1 | Output strobe, two cycles after input |
| out_data | output | OUT_W | Signed narrowed sample |
| out_ovf | output | 1 | High-bit step changed the value |

## Verification
The bench sends every 12-bit input code through all four rounding modes and both range modes. This covers exact halves of either sign, where a design that mixes up the half rules is off by one on alternate codes. It also covers the largest positive code, where a design that drops the rounding carry wraps to the most negative value instead of clipping. Modes change on every sample, so a design that takes the range mode from the wrong pipeline stage gives the wrong result right after each switch. A second instance with no dropped bits and a wider output catches any rounding that is not bypassed and any sign extension that is missing.

// File: rtl/rq_pkg.sv
package rq_pkg;

  typedef enum logic [1:0] {
    RND_TRUNC     = 2'd0,
    RND_HALF_UP   = 2'd1,
    RND_HALF_AWAY = 2'd2,
    RND_HALF_EVEN = 2'd3
  } rnd_mode_e;

  // Carry into the kept field, given the mode, the sign, the kept LSB and
  // whether the dropped part is at least, or more than, one half.
  function automatic logic rnd_carry(rnd_mode_e m, logic neg, logic kept_lsb,
                                     logic half_bit, logic below_nz);
    logic above_half;
    logic at_or_above;
    above_half  = half_bit & below_nz;
    at_or_above = half_bit;
    case (m)
      RND_TRUNC:     rnd_carry = 1'b0;
      RND_HALF_UP:   rnd_carry = at_or_above;
      RND_HALF_AWAY: rnd_carry = neg ? above_half : at_or_above;
      default:       rnd_carry = half_bit & (below_nz | kept_lsb);
    endcase
  endfunction

endpackage

// File: rtl/rq_round.sv
module rq_round
  import rq_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int DROP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [IN_W-1:0]        in_data,
  input  logic [1:0]             round_mode,
  input  logic                   sat_mode,
  output logic                   r_valid,
  output logic [IN_W-DROP:0]     r_data,
  output logic                   r_sat
);
  localparam int KEEP_W = IN_W - DROP;
  localparam int RW     = KEEP_W + 1;
  localparam int FR_W   = (DROP > 0) ? DROP : 1;
  localparam logic [FR_W-1:0] BELOW_MASK = (FR_W'(1) << (FR_W - 1)) - FR_W'(1);

  logic [RW-1:0] r_next;

  generate
    if (DROP == 0) begin : g_bypass
      always_comb r_next = {in_data[IN_W-1], in_data};
    end else begin : g_round
      logic [KEEP_W-1:0] kept;
      logic [FR_W-1:0]   frac;
      logic              carry;
      always_comb begin
        kept   = in_data[IN_W-1:DROP];
        frac   = in_data[FR_W-1:0];
        carry  = rnd_carry(rnd_mode_e'(round_mode), in_data[IN_W-1], kept[0],
                           frac[FR_W-1], |(frac & BELOW_MASK));
        r_next = {kept[KEEP_W-1], kept} + RW'(carry);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_data  <= '0;
      r_sat   <= 1'b0;
    end else begin
      r_valid <= in_valid;
      r_data  <= r_next;
      r_sat   <= sat_mode;
    end
  end

endmodule

// File: rtl/rq_msb.sv
module rq_msb #(
  parameter int RW    = 9,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             r_valid,
  input  logic [RW-1:0]    r_data,
  input  logic             r_sat,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_ovf
);
  logic [OUT_W-1:0] o_next;
  logic             ovf_next;

  generate
    if (OUT_W >= RW) begin : g_extend
      always_comb begin
        o_next   = OUT_W'($signed(r_data));
        ovf_next = 1'b0;
      end
    end else begin : g_narrow
      localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};
      localparam logic [OUT_W-1:0] MAX_NEG = {1'b1, {(OUT_W-1){1'b0}}};
      logic [RW-OUT_W:0] upper;
      logic              fits;
      always_comb begin
        upper = r_data[RW-1:OUT_W-1];
        fits  = (&upper) | ~(|upper);
        if (fits)       o_next = r_data[OUT_W-1:0];
        else if (r_sat) o_next = r_data[RW-1] ? MAX_NEG : MAX_POS;
        else            o_next = r_data[OUT_W-1:0];
        ovf_next = ~fits;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= r_valid;
      out_data  <= o_next;
      out_ovf   <= ovf_next & r_valid;
    end
  end

endmodule

// File: rtl/rq_requant.sv
module rq_requant #(
  parameter int IN_W  = 12,
  parameter int DROP  = 4,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       round_mode,
  input  logic             sat_mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_ovf
);
  localparam int RW = IN_W - DROP + 1;

  // Stage-1 results, named for the checker.
  logic          rnd_valid;
  logic [RW-1:0] rnd_val;
  logic          rnd_sat;

  rq_round #(.IN_W(IN_W), .DROP(DROP)) u_round (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .round_mode(round_mode), .sat_mode(sat_mode),
    .r_valid(rnd_valid), .r_data(rnd_val), .r_sat(rnd_sat)
  );

  rq_msb #(.RW(RW), .OUT_W(OUT_W)) u_msb (
    .clk(clk), .rst_n(rst_n), .r_valid(rnd_valid), .r_data(rnd_val),
    .r_sat(rnd_sat), .out_valid(out_valid), .out_data(out_data),
    .out_ovf(out_ovf)
  );

endmodule

// File: rtl/rq_requant_chk.sv
module rq_requant_chk #(
  parameter int IN_W  = 12,
  parameter int DROP  = 4,
  parameter int OUT_W = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [IN_W-1:0]      in_data,
  input logic [1:0]           round_mode,
  input logic                 sat_mode,
  input logic [IN_W-DROP:0]   rnd_val,
  input logic                 out_valid,
  input logic [OUT_W-1:0]     out_data,
  input logic                 out_ovf
);
  localparam int RW = IN_W - DROP + 1;

  logic [1:0]            cyc;
  logic [IN_W-1:0]       prev_in;
  logic [1:0]            prev_mode;
  logic [1:0]            sat_pipe;
  logic [RW-1:0]         prev_rnd;
  logic signed [IN_W:0]  floor_v;
  logic signed [IN_W+1:0] step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 2'd0;
    end else if (cyc != 2'd2) begin
      cyc <= cyc + 2'd1;
    end
    prev_in   <= in_data;
    prev_mode <= round_mode;
    sat_pipe  <= {sat_pipe[0], sat_mode};
    prev_rnd  <= rnd_val;
  end

  always_comb begin
    floor_v = $signed({prev_in[IN_W-1], prev_in}) >>> DROP;
    step    = $signed(rnd_val) - floor_v;
  end

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R3
  trunc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && prev_mode == 2'd0) |-> (step == 0));

  // R6
  rnd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0) |-> (step == 0 || step == 1));

  // R10
  sat_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && out_valid && out_ovf && sat_pipe[1]) |->
      (out_data == {1'b0, {(OUT_W-1){1'b1}}} || out_data == {1'b1, {(OUT_W-1){1'b0}}}));

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && out_valid && !out_ovf) |-> ($signed(out_data) == $signed(prev_rnd)));

endmodule

bind rq_requant rq_requant_chk #(.IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .round_mode(round_mode), .sat_mode(sat_mode), .rnd_val(rnd_val),
  .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/rq_requant_tb.sv
module rq_requant_tb;
  localparam int IN_W  = 12;
  localparam int DROP  = 4;
  localparam int OUT_W = 6;
  localparam int WIDE_W = 16;

  typedef struct {
    int    val;
    bit    ovf;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [1:0] round_mode = 2'd0;
  logic sat_mode = 1'b0;
  logic out_valid, out_ovf, w_valid, w_ovf;
  logic [OUT_W-1:0] out_data;
  logic [WIDE_W-1:0] w_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t q_main[$];
  exp_t q_wide[$];

  always #2.5 clk = ~clk;

  rq_requant #(.IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .round_mode(round_mode), .sat_mode(sat_mode),
    .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf));

  rq_requant #(.IN_W(IN_W), .DROP(0), .OUT_W(WIDE_W)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .round_mode(round_mode), .sat_mode(sat_mode),
    .out_valid(w_valid), .out_data(w_data), .out_ovf(w_ovf));

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model: floor, remainder, then the half rule.
  function automatic int model_round(int x, int m);
    int q, r, h;
    q = x >>> DROP;
    r = x - (q <<< DROP);
    h = 1 << (DROP - 1);
    case (m)
      0: return q;
      1: return q + ((r >= h) ? 1 : 0);
      2: return (x >= 0) ? q + ((r >= h) ? 1 : 0) : q + ((r > h) ? 1 : 0);
      default: begin
        if (r > h) return q + 1;
        if (r < h) return q;
        return q + (q & 1);
      end
    endcase
  endfunction

  function automatic int model_fit(int v, bit sat);
    int lo, hi, w;
    lo = -(1 << (OUT_W - 1));
    hi = (1 << (OUT_W - 1)) - 1;
    if (v >= lo && v <= hi) return v;
    if (sat) return (v < lo) ? lo : hi;
    w = v & ((1 << OUT_W) - 1);
    if (w > hi) w = w - (1 << OUT_W);
    return w;
  endfunction

  function automatic string tag_of(int m, bit ovf, bit sat);
    if (ovf) return sat ? "R10" : "R9";
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic push_inputs(int x, int m, bit sat);
    @(negedge clk);
    in_valid   = 1'b1;
    in_data    = IN_W'(x);
    round_mode = 2'(m);
    sat_mode   = sat;
    // R8 R11: no drop, wide output, value kept and sign extended
    q_wide.push_back('{val: x, ovf: 1'b0, tag: "R8/R11"});
  endtask

  task automatic send(int x, int m, bit sat);
    int rv, fv;
    rv = model_round(x, m);
    fv = model_fit(rv, sat);
    push_inputs(x, m, sat);
    q_main.push_back('{val: fv, ovf: (fv != rv), tag: tag_of(m, fv != rv, sat)});
  endtask

  task automatic send_lit(int x, int m, bit sat, int e, bit ovf, string tag);
    push_inputs(x, m, sat);
    q_main.push_back('{val: e, ovf: ovf, tag: tag});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_main.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = q_main.pop_front();
          check($signed(out_data) == e.val, e.tag, $signed(out_data), e.val);
          check(out_ovf == e.ovf, {e.tag, " R12 flag"}, out_ovf, e.ovf);
        end
      end else begin
        check(out_ovf == 1'b0, "R12 flag without valid", out_ovf, 0);
      end
      if (w_valid) begin
        if (q_wide.size() == 0) begin
          check(1'b0, "R2 unexpected wide valid", 1, 0);
        end else begin
          exp_t e;
          e = q_wide.pop_front();
          check($signed(w_data) == e.val, e.tag, $signed(w_data), e.val);
          check(w_ovf == 1'b0, "R11 flag", w_ovf, 0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(out_ovf == 1'b0, "R1 ovf in reset", out_ovf, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    // R2: single sample, count the cycles
    send_lit(16, 0, 1'b0, 1, 1'b0, "R2");
    @(negedge clk);
    in_valid = 1'b0;
    idle(3);

    // Literal cases from the requirements
    send_lit(-20, 0, 1'b0, -2, 1'b0, "R3");
    send_lit(20, 0, 1'b0, 1, 1'b0, "R3");
    send_lit(-8, 1, 1'b0, 0, 1'b0, "R4");
    send_lit(-8, 2, 1'b0, -1, 1'b0, "R5");
    send_lit(8, 2, 1'b0, 1, 1'b0, "R5");
    send_lit(-24, 3, 1'b0, -2, 1'b0, "R6");
    send_lit(-8, 3, 1'b0, 0, 1'b0, "R6");
    send_lit(8, 3, 1'b0, 0, 1'b0, "R6");
    send_lit(24, 3, 1'b0, 2, 1'b0, "R6");
    send_lit(40, 3, 1'b0, 2, 1'b0, "R6");
    send_lit(2047, 1, 1'b1, 31, 1'b1, "R7 clip");
    send_lit(2047, 1, 1'b0, 0, 1'b1, "R7 wrap");
    send_lit(-2048, 0, 1'b1, -32, 1'b1, "R10");
    send_lit(-16, 0, 1'b0, -1, 1'b0, "R11 minus one");
    idle(4);

    // R13: every input code, all modes, modes switched per sample
    for (int x = -(1 << (IN_W - 1)); x < (1 << (IN_W - 1)); x++) begin
      for (int k = 0; k < 8; k++) begin
        send(x, k % 4, k[2] ^ x[0]);
      end
      if ((x & 255) == 0) idle(2);
    end
    idle(6);
    done = 1'b1;
    check(q_main.size() == 0, "R2 pending main", q_main.size(), 0);
    check(q_wide.size() == 0, "R2 pending wide", q_wide.size(), 0);
    finish_run();
  end

endmodule